// File: doc/BRIEF.md
# Arithmetic Word Shifter with Status Flags

This block shifts a 32-bit data word by a signed count. A positive count shifts left and a negative count shifts right arithmetically. Alongside the shifted word it produces processor-style status bits. Carry reports bits that were pushed out of the word. Overflow reports a left shift whose true value does not fit in a signed 32-bit word. The "advance" overflow bit reports that the two top result bits differ, which warns that one further doubling would overflow.

The result and the carry, overflow and advance bits are combinational outputs of the current inputs. Two sticky bits record whether any accepted operation has raised overflow or advance overflow since they were last cleared. An operation is accepted when a valid strobe is high at a clock edge. A clear input and the reset both return the sticky bits to zero. A count of zero passes the word through. The most negative count, -32, floods the word with its sign bit.

Top module: `ashf_top`

## Requirements
- R1: The count input is a 6-bit two's-complement number in the range -32 to +31. Count bit 5 is the sign.
- R2: With a count of zero, the result equals the data word and both carry and overflow are 0.
- R3: With a count of -32, every result bit equals data bit 31 and overflow is 0. Carry is 1 exactly when the data word is nonzero.
- R4: With a count n from 1 to 31, the data word is sign-extended to 64 bits and shifted left by n. The result is the low 32 bits of that product. Carry is 1 when any of the product's upper 32 bits is 1.
- R5: With a count from 1 to 31, overflow is 1 exactly when the 64-bit product lies outside the range -2^31 to 2^31-1.
- R6: With a count -m, where m is 1 to 31, the result is the data word shifted right arithmetically by m and overflow is 0. Carry is 1 when any of the m low data bits shifted out is 1.
- R7: For every count, the advance bit equals result bit 31 XOR result bit 30.
- R8: On a clock edge with valid high and clear low, the sticky overflow bit becomes its old value OR the current overflow. An accepted operation with overflow 0 leaves it unchanged.
- R9: On a clock edge with valid high and clear low, the sticky advance bit becomes its old value OR the current advance bit.
- R10: On a clock edge with valid low and clear low, both sticky bits keep their values, whatever the data and count inputs are.
- R11: Reset, and a clock edge with clear high, set both sticky bits to 0. Clear takes priority over a valid operation at the same edge.
- R12: The result, carry, overflow and advance outputs follow the data and count inputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; sticky bits update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Accepts the current operation into the sticky bits |
| clr_i | input | 1 | Clears both sticky bits at the next edge |
| data_i | input | 32 | Word to be shifted |
| cnt_i | input | 6 | Signed shift count |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry of the current operation |
| ovf_o | output | 1 | Overflow of the current operation |
| adv_o | output | 1 | Advance overflow of the current operation |
| sticky_ovf_o | output | 1 | Accumulated overflow |
| sticky_adv_o | output | 1 | Accumulated advance overflow |

## Verification
The assertions assume that the data and count inputs are stable and known from the first clock edge after reset. They also assume that valid and clear are never unknown. The bench sets every input to a defined value at time zero and changes inputs only at falling edges. The combinational checks at rising edges therefore see settled values. Before each table entry the bench clears the sticky bits, so each entry's sticky outcome depends on that entry alone.

// File: rtl/ashf_pkg.sv
package ashf_pkg;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2,
        SH_FLOOD = 2'd3
    } sh_kind_e;

    typedef struct packed {
        logic ovf;
        logic adv;
    } sticky_t;

endpackage

// File: rtl/ashf_count_decode.sv
module ashf_count_decode
    import ashf_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic [CW-1:0] cnt_i,
    output sh_kind_e      kind_o,
    output logic [CW-1:0] mag_o
);

    localparam logic [CW-1:0] MOST_NEG = {1'b1, {(CW-1){1'b0}}};

    always_comb begin
        kind_o = SH_NONE;
        mag_o  = '0;
        if (cnt_i == '0) begin
            kind_o = SH_NONE;
        end else if (!cnt_i[CW-1]) begin
            kind_o = SH_LEFT;
            mag_o  = cnt_i;
        end else if (cnt_i == MOST_NEG) begin
            kind_o = SH_FLOOD;
        end else begin
            kind_o = SH_RIGHT;
            mag_o  = -cnt_i;
        end
    end

endmodule

// File: rtl/ashf_shift_core.sv
module ashf_shift_core
    import ashf_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input  logic [W-1:0]  data_i,
    input  sh_kind_e      kind_i,
    input  logic [CW-1:0] mag_i,
    output logic [W-1:0]  result_o,
    output logic          carry_o,
    output logic          ovf_o
);

    localparam int WW = 2 * W;

    logic [WW-1:0] wide;
    logic [W:0]    top_part;
    logic [W-1:0]  right_val;
    logic [W-1:0]  lost_mask;

    always_comb begin
        wide      = {{W{data_i[W-1]}}, data_i} << mag_i;
        top_part  = wide[WW-1:W-1];
        right_val = W'($signed(data_i) >>> mag_i);
        lost_mask = ~({W{1'b1}} << mag_i);
    end

    always_comb begin
        result_o = data_i;
        carry_o  = 1'b0;
        ovf_o    = 1'b0;
        unique case (kind_i)
            SH_NONE: begin
                result_o = data_i;
            end
            SH_LEFT: begin
                result_o = wide[W-1:0];
                carry_o  = |wide[WW-1:W];
                ovf_o    = !((&top_part) || !(|top_part));
            end
            SH_RIGHT: begin
                result_o = right_val;
                carry_o  = |(data_i & lost_mask);
            end
            SH_FLOOD: begin
                result_o = {W{data_i[W-1]}};
                carry_o  = |data_i;
            end
            default: begin
                result_o = data_i;
            end
        endcase
    end

endmodule

// File: rtl/ashf_sticky.sv
module ashf_sticky
    import ashf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    valid_i,
    input  logic    clr_i,
    input  logic    ovf_i,
    input  logic    adv_i,
    output sticky_t sticky_o
);

    sticky_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (valid_i) begin
            st_d.ovf = st_q.ovf | ovf_i;
            st_d.adv = st_q.adv | adv_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sticky_o = st_q;

endmodule

// File: rtl/ashf_top.sv
module ashf_top
    import ashf_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = $clog2(W) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          clr_i,
    input  logic [W-1:0]  data_i,
    input  logic [CW-1:0] cnt_i,
    output logic [W-1:0]  result_o,
    output logic          carry_o,
    output logic          ovf_o,
    output logic          adv_o,
    output logic          sticky_ovf_o,
    output logic          sticky_adv_o
);

    sh_kind_e      kind;
    logic [CW-1:0] mag;
    sticky_t       sticky;

    ashf_count_decode #(.CW(CW)) u_dec (
        .cnt_i  (cnt_i),
        .kind_o (kind),
        .mag_o  (mag)
    );

    ashf_shift_core #(.W(W), .CW(CW)) u_core (
        .data_i   (data_i),
        .kind_i   (kind),
        .mag_i    (mag),
        .result_o (result_o),
        .carry_o  (carry_o),
        .ovf_o    (ovf_o)
    );

    assign adv_o = result_o[W-1] ^ result_o[W-2];

    ashf_sticky u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_i),
        .clr_i    (clr_i),
        .ovf_i    (ovf_o),
        .adv_i    (adv_o),
        .sticky_o (sticky)
    );

    assign sticky_ovf_o = sticky.ovf;
    assign sticky_adv_o = sticky.adv;

endmodule

// File: rtl/ashf_checker.sv
module ashf_checker #(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_i,
    input logic          clr_i,
    input logic [W-1:0]  data_i,
    input logic [CW-1:0] cnt_i,
    input logic [W-1:0]  result_o,
    input logic          carry_o,
    input logic          ovf_o,
    input logic          sticky_ovf_o,
    input logic          sticky_adv_o,
    input logic          adv_o
);

    localparam logic [CW-1:0] MOST_NEG = {1'b1, {(CW-1){1'b0}}};

    assert_zero_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0) |-> (result_o == data_i && !carry_o && !ovf_o));

    assert_flood_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == MOST_NEG) |-> (result_o == {W{data_i[W-1]}} && !ovf_o
                                 && carry_o == (data_i != '0)));

    assert_right_no_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i[CW-1] && cnt_i != MOST_NEG) |-> !ovf_o);

    assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clr_i && ovf_o) |=> sticky_ovf_o);

    assert_sticky_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clr_i && adv_o) |=> sticky_adv_o);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !clr_i) |=> ($stable(sticky_ovf_o) && $stable(sticky_adv_o)));

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!sticky_ovf_o && !sticky_adv_o));

    assert_no_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && sticky_ovf_o) |=> sticky_ovf_o);

endmodule

bind ashf_top ashf_checker #(.W(W), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (valid_i),
    .clr_i        (clr_i),
    .data_i       (data_i),
    .cnt_i        (cnt_i),
    .result_o     (result_o),
    .carry_o      (carry_o),
    .ovf_o        (ovf_o),
    .sticky_ovf_o (sticky_ovf_o),
    .sticky_adv_o (sticky_adv_o),
    .adv_o        (adv_o)
);

// File: tb/tb_ashf_top.sv
module tb_ashf_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        clr_i = 1'b0;
    logic [31:0] data_i = '0;
    logic [5:0]  cnt_i = '0;
    logic [31:0] result_o;
    logic        carry_o, ovf_o, adv_o, sticky_ovf_o, sticky_adv_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ashf_top dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .clr_i(clr_i),
        .data_i(data_i), .cnt_i(cnt_i), .result_o(result_o),
        .carry_o(carry_o), .ovf_o(ovf_o), .adv_o(adv_o),
        .sticky_ovf_o(sticky_ovf_o), .sticky_adv_o(sticky_adv_o)
    );

    typedef struct packed {
        logic [31:0] d;
        logic [5:0]  c;
        logic [31:0] r;
        logic        cy;
        logic        v;
        logic        a;
    } vec_t;

    localparam int NV = 18;
    // count encoding per R1: 6-bit two's complement, 6'h20 = -32
    localparam vec_t VECS [NV] = '{
        '{32'h12345678, 6'h00, 32'h12345678, 1'b0, 1'b0, 1'b0},
        '{32'h40000000, 6'h00, 32'h40000000, 1'b0, 1'b0, 1'b1},
        '{32'h00000001, 6'h04, 32'h00000010, 1'b0, 1'b0, 1'b0},
        '{32'h40000000, 6'h01, 32'h80000000, 1'b0, 1'b1, 1'b1},
        '{32'hFFFFFFFF, 6'h01, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b0},
        '{32'h80000000, 6'h1F, 32'h00000000, 1'b1, 1'b1, 1'b0},
        '{32'h00000003, 6'h1F, 32'h80000000, 1'b1, 1'b1, 1'b1},
        '{32'h12345678, 6'h04, 32'h23456780, 1'b1, 1'b1, 1'b0},
        '{32'h80000000, 6'h20, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0},
        '{32'h00000000, 6'h20, 32'h00000000, 1'b0, 1'b0, 1'b0},
        '{32'h7FFFFFFF, 6'h20, 32'h00000000, 1'b1, 1'b0, 1'b0},
        '{32'h80000001, 6'h3F, 32'hC0000000, 1'b1, 1'b0, 1'b0},
        '{32'h0000000F, 6'h3C, 32'h00000000, 1'b1, 1'b0, 1'b0},
        '{32'h00000010, 6'h3C, 32'h00000001, 1'b0, 1'b0, 1'b0},
        '{32'h40000000, 6'h21, 32'h00000000, 1'b1, 1'b0, 1'b0},
        '{32'hFFFFFFFF, 6'h21, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0},
        '{32'hFFFFFFF0, 6'h03, 32'hFFFFFF80, 1'b1, 1'b0, 1'b0},
        '{32'hC0000000, 6'h01, 32'h80000000, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string kind_tag(input logic [5:0] c);
        if (c == 6'h00)      return "R2";
        else if (c == 6'h20) return "R3";
        else if (c[5])       return "R6";
        else                 return "R4";
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(100000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset sticky_ovf", 32'(sticky_ovf_o), 32'd0);
        chk("R11 reset sticky_adv", 32'(sticky_adv_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1, R2..R7 combinational (R12), R8/R9 sticky per entry
        for (int i = 0; i < NV; i++) begin
            clr_i = 1'b1; valid_i = 1'b0;
            @(negedge clk);
            clr_i = 1'b0;
            data_i = VECS[i].d; cnt_i = VECS[i].c; valid_i = 1'b1;
            #1;
            chk($sformatf("%s/R1/R12 result v%0d", kind_tag(VECS[i].c), i), result_o, VECS[i].r);
            chk($sformatf("%s carry v%0d", kind_tag(VECS[i].c), i), 32'(carry_o), 32'(VECS[i].cy));
            chk($sformatf("R5 ovf v%0d", i), 32'(ovf_o), 32'(VECS[i].v));
            chk($sformatf("R7 adv v%0d", i), 32'(adv_o), 32'(VECS[i].a));
            @(negedge clk);
            valid_i = 1'b0;
            chk($sformatf("R8 sticky_ovf v%0d", i), 32'(sticky_ovf_o), 32'(VECS[i].v));
            chk($sformatf("R9 sticky_adv v%0d", i), 32'(sticky_adv_o), 32'(VECS[i].a));
        end

        // R8/R9: accumulation survives a later clean operation
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0; data_i = 32'h40000000; cnt_i = 6'h01; valid_i = 1'b1;
        @(negedge clk);
        data_i = 32'h00000001; cnt_i = 6'h04;
        @(negedge clk);
        valid_i = 1'b0;
        chk("R8 sticky_ovf kept after clean op", 32'(sticky_ovf_o), 32'd1);
        chk("R9 sticky_adv kept after clean op", 32'(sticky_adv_o), 32'd1);

        // R10: idle cycles with flag-raising inputs change nothing
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0; valid_i = 1'b0; data_i = 32'h40000000; cnt_i = 6'h01;
        #1;
        chk("R10 ovf present while idle", 32'(ovf_o), 32'd1);
        repeat (3) @(negedge clk);
        chk("R10 sticky_ovf idle", 32'(sticky_ovf_o), 32'd0);
        chk("R10 sticky_adv idle", 32'(sticky_adv_o), 32'd0);

        // R11: clear wins over a simultaneous valid operation
        valid_i = 1'b1;
        @(negedge clk);
        chk("R11 setup sticky_ovf", 32'(sticky_ovf_o), 32'd1);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0; valid_i = 1'b0;
        chk("R11 clear priority sticky_ovf", 32'(sticky_ovf_o), 32'd0);
        chk("R11 clear priority sticky_adv", 32'(sticky_adv_o), 32'd0);

        // R11: reset mid-run clears sticky bits
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R11 async reset sticky_ovf", 32'(sticky_ovf_o), 32'd0);
        chk("R11 async reset sticky_adv", 32'(sticky_adv_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule